// File: doc/BRIEF.md
# Vertical Sync Extractor with Timeout

This block recovers the start of each video field from a sliced, active-low composite sync bit. A free-running system clock samples that bit. Every low pulse on the input is timed. Equalizing pulses and ordinary line sync pulses are short lows. The broad pulses of the vertical interval stay low for most of a half line. The first broad low that ends with a rising edge starts an active-low vertical pulse. Some inputs carry no serrations and hold one long low through the vertical interval instead. For those inputs the pulse is forced once the low has lasted a fixed timeout. In both cases the pulse lasts a fixed number of clocks, and its falling edge marks the start of the vertical period.

All times are parameters counted in clock cycles. By default they derive from a clock-rate parameter `CLK_MHZ`:

| Parameter | Default | Meaning |
|---|---|---|
| `SERR_MIN_CYC` | 16 µs | Serration threshold |
| `TIMEOUT_CYC` | 50 µs | Fallback timeout |
| `VS_WIDTH_CYC` | 280 µs | Output pulse width |
| `HS_MIN_CYC` to `HS_MAX_CYC` | 3 µs to 7 µs | Window for a normal horizontal pulse |

Once a pulse has fired, a re-arm latch blocks further triggers. The latch opens again only after the output pulse has ended and one normal horizontal pulse has been seen. This gives exactly one vertical pulse per field.

Top module: `vsync_extractor`

## Requirements
- R1: While reset is high and on the first cycle after it, `vsync_n` is 1. The block leaves reset armed, so the first qualifying event of the first field fires.
- R2: A low period is measured on the conditioned input. If it is longer than `SERR_MIN_CYC` cycles and ends in a rising edge while the block is armed, `vsync_n` goes to 0 on the fifth rising clock edge after the input rises (with `SYNC_STAGES` = 2, counting from the first edge that samples the new level).
- R3: A low period of `SERR_MIN_CYC` cycles or fewer never starts a pulse.
- R4: The input may stay low for more than `TIMEOUT_CYC` cycles while the block is armed. Then `vsync_n` goes to 0 on rising edge number `TIMEOUT_CYC` + 5 after the input fell, while the input is still low.
- R5: Every pulse holds `vsync_n` at 0 for exactly `VS_WIDTH_CYC` cycles, whichever trigger started it.
- R6: After a pulse, no trigger takes effect until `vsync_n` has returned to 1 and a low period of `HS_MIN_CYC` to `HS_MAX_CYC` cycles has ended. Each field therefore yields exactly one pulse.
- R7: A level on the input that lasts a single clock cycle is ignored: it neither ends nor starts a low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| csync_n | input | 1 | Sliced composite sync, low during sync pulses, asynchronous to clk |
| vsync_n | output | 1 | Registered vertical sync, low for one pulse per field |

## Verification
The bench builds the block with `CLK_MHZ` = 1. With that setting one clock stands for one microsecond of the synthetic timeline: a line is 64 cycles, a serration is 27 low and 5 high, and an equalizing pulse is 2 low and 30 high. The settings give a 16-cycle serration threshold, a 50-cycle timeout and a 280-cycle pulse. This keeps whole vertical intervals short enough that several fields can each be checked for pulse start, width and count. The fields include NTSC-like and PAL-like serrated fields and broad lows with no serrations. The short timings also allow exact boundary lows of 16 and 17 cycles, a one-cycle glitch inside a broad low, and serrations arriving before re-arm.

// File: rtl/vsx_pkg.sv
package vsx_pkg;

  // Qualified events produced by the low-time measurement each cycle
  typedef struct packed {
    logic ser_edge;  // rising edge that ends a serration-length low
    logic timeout;   // low level has lasted the fallback delay
    logic h_line;    // rising edge that ends a normal-width line pulse
  } vsx_evt_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/vsx_input_cond.sv
module vsx_input_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_n,
  output logic lvl,
  output logic fall,
  output logic rise
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         hold_q;
  logic         lvl_d;

  // Synchronizer chain, one flop per stage
  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b1;
    else     sync_q[0] <= din_n;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[g] <= 1'b1;
      else     sync_q[g] <= sync_q[g-1];
    end
  end

  // Glitch filter: accept a new level only after two equal samples
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b1;
      lvl    <= 1'b1;
      lvl_d  <= 1'b1;
    end else begin
      hold_q <= sync_q[MSB];
      if (sync_q[MSB] == hold_q) lvl <= hold_q;
      lvl_d <= lvl;
    end
  end

  assign fall = lvl_d & ~lvl;
  assign rise = ~lvl_d & lvl;

  AST_FILTER_TWO_SAMPLES: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl) |-> ($past(sync_q[MSB]) == lvl && $past(hold_q) == lvl)); // R7

endmodule

// File: rtl/vsx_low_timer.sv
module vsx_low_timer
  import vsx_pkg::*;
#(
  parameter int SERR_MIN_CYC = 16,
  parameter int TIMEOUT_CYC  = 50,
  parameter int HS_MIN_CYC   = 3,
  parameter int HS_MAX_CYC   = 7
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     lvl,
  input  logic     fall,
  input  logic     rise,
  output vsx_evt_t evt
);

  localparam int CNT_TOP = max3(SERR_MIN_CYC, TIMEOUT_CYC, HS_MAX_CYC);
  localparam int CNT_W   = $clog2(CNT_TOP + 2);

  localparam logic [CNT_W-1:0] SERR_L = CNT_W'(SERR_MIN_CYC);
  localparam logic [CNT_W-1:0] TMO_L  = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] HMIN_L = CNT_W'(HS_MIN_CYC);
  localparam logic [CNT_W-1:0] HMAX_L = CNT_W'(HS_MAX_CYC);
  localparam logic [CNT_W-1:0] ONE_L  = CNT_W'(1);

  logic [CNT_W-1:0] low_cnt;

  // Saturating count of cycles spent low since the last falling edge
  always_ff @(posedge clk) begin
    if (rst)                         low_cnt <= '0;
    else if (fall)                   low_cnt <= ONE_L;
    else if (!lvl && low_cnt != '1)  low_cnt <= low_cnt + ONE_L;
  end

  always_comb begin
    evt.ser_edge = rise && (low_cnt > SERR_L);
    evt.timeout  = !lvl && !fall && (low_cnt == TMO_L);
    evt.h_line   = rise && (low_cnt >= HMIN_L) && (low_cnt <= HMAX_L);
  end

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt.ser_edge, evt.timeout})); // R4
  AST_TIMEOUT_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    evt.timeout |-> (!lvl && $past(!lvl))); // R4
  AST_SER_ENDS_LOW: assert property (@(posedge clk) disable iff (rst)
    evt.ser_edge |-> $past(!lvl)); // R2
  AST_SHORT_LOW_NO_SER: assert property (@(posedge clk) disable iff (rst)
    (rise && low_cnt <= SERR_L) |-> !evt.ser_edge); // R3

endmodule

// File: rtl/vsx_pulse_gen.sv
module vsx_pulse_gen
  import vsx_pkg::*;
#(
  parameter int VS_WIDTH_CYC = 280
) (
  input  logic     clk,
  input  logic     rst,
  input  vsx_evt_t evt,
  output logic     vsync_n
);

  localparam int WW = $clog2(VS_WIDTH_CYC + 1);
  localparam logic [WW-1:0] WIDTH_L = WW'(VS_WIDTH_CYC);
  localparam logic [WW-1:0] ONE_W   = WW'(1);

  logic [WW-1:0] wcnt;
  logic          armed;
  logic          fire;

  assign fire = armed && (evt.ser_edge || evt.timeout);

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync_n <= 1'b1;
      wcnt    <= '0;
      armed   <= 1'b1;
    end else if (fire) begin
      vsync_n <= 1'b0;
      wcnt    <= ONE_W;
      armed   <= 1'b0;
    end else if (!vsync_n) begin
      if (wcnt == WIDTH_L) vsync_n <= 1'b1;
      else                 wcnt    <= wcnt + ONE_W;
    end else if (!armed && evt.h_line) begin
      armed <= 1'b1;
    end
  end

  AST_RESET_HIGH: assert property (@(posedge clk)
    rst |=> vsync_n); // R1
  AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> (wcnt >= ONE_W && wcnt <= WIDTH_L)); // R5
  AST_RELEASE_AT_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync_n) |-> $past(wcnt) == WIDTH_L); // R5
  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
    fire |-> vsync_n); // R6

endmodule

// File: rtl/vsync_extractor.sv
module vsync_extractor
  import vsx_pkg::*;
#(
  parameter int CLK_MHZ      = 27,
  parameter int SYNC_STAGES  = 2,
  parameter int SERR_MIN_CYC = 16 * CLK_MHZ,
  parameter int TIMEOUT_CYC  = 50 * CLK_MHZ,
  parameter int VS_WIDTH_CYC = 280 * CLK_MHZ,
  parameter int HS_MIN_CYC   = 3 * CLK_MHZ,
  parameter int HS_MAX_CYC   = 7 * CLK_MHZ
) (
  input  logic clk,
  input  logic rst,
  input  logic csync_n,
  output logic vsync_n
);

  logic     lvl, fall, rise;
  vsx_evt_t evt;

  vsx_input_cond #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_cond (
    .clk  (clk),
    .rst  (rst),
    .din_n(csync_n),
    .lvl  (lvl),
    .fall (fall),
    .rise (rise)
  );

  vsx_low_timer #(
    .SERR_MIN_CYC(SERR_MIN_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .HS_MIN_CYC  (HS_MIN_CYC),
    .HS_MAX_CYC  (HS_MAX_CYC)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .lvl (lvl),
    .fall(fall),
    .rise(rise),
    .evt (evt)
  );

  vsx_pulse_gen #(
    .VS_WIDTH_CYC(VS_WIDTH_CYC)
  ) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .vsync_n(vsync_n)
  );

endmodule

// File: tb/vsync_extractor_bench.sv
module vsync_extractor_bench;

  localparam int T_OUT = 50;
  localparam int WIDTH = 280;
  localparam int LAT   = 5;

  // Field table: pre-equalizing count, serration count, broad-low length
  localparam int NFLD = 4;
  localparam int FIELD_TAB [NFLD][3] = '{
    '{6, 6, 0},     // NTSC-like serrated field
    '{5, 5, 0},     // PAL-like serrated field
    '{6, 0, 192},   // no serrations, broad low past the timeout
    '{6, 0, 40}     // no serrations, broad low under the timeout
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csync_n = 1'b1;
  wire  vsync_n;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int n_pulse = 0;
  int fall_at = -1;
  int last_width = -1;
  logic prev_v = 1'b1;

  vsync_extractor #(.CLK_MHZ(1)) u_vsync_extractor (
    .clk    (clk),
    .rst    (rst),
    .csync_n(csync_n),
    .vsync_n(vsync_n)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_v && !vsync_n) begin
        n_pulse = n_pulse + 1;
        fall_at = cyc;
      end
      if (!prev_v && vsync_n) last_width = cyc - fall_at;
    end
    prev_v = vsync_n;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One low then high period, entered and left at a falling clock edge
  task automatic seg(input int lo, input int hi, output int t_fall, output int t_rise);
    csync_n = 1'b0;
    t_fall = cyc;
    repeat (lo) @(negedge clk);
    csync_n = 1'b1;
    t_rise = cyc;
    repeat (hi) @(negedge clk);
  endtask

  task automatic lines(input int n);
    int a, b;
    for (int k = 0; k < n; k++) seg(5, 59, a, b);
  endtask

  task automatic equal(input int n);
    int a, b;
    for (int k = 0; k < n; k++) seg(2, 30, a, b);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int tf, tr, base, exp_fall;
    repeat (6) @(negedge clk);
    check("R1 output high in reset", int'(vsync_n), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 output high after reset", int'(vsync_n), 1);

    // Table-driven fields
    for (int i = 0; i < NFLD; i++) begin
      lines(8);
      base = n_pulse;
      exp_fall = -1;
      equal(FIELD_TAB[i][0]);
      if (FIELD_TAB[i][1] > 0) begin
        for (int k = 0; k < FIELD_TAB[i][1]; k++) begin
          seg(27, 5, tf, tr);
          if (k == 0) exp_fall = tr + LAT;
        end
      end else begin
        seg(FIELD_TAB[i][2], 32, tf, tr);
        exp_fall = (FIELD_TAB[i][2] > T_OUT) ? tf + LAT + T_OUT : tr + LAT;
      end
      equal(6);
      lines(8);
      check((FIELD_TAB[i][1] > 0 || FIELD_TAB[i][2] <= T_OUT) ?
            "R2 pulse start" : "R4 timeout start", fall_at, exp_fall);
      check("R5 pulse width", last_width, WIDTH);
      check("R6 one pulse per field", n_pulse - base, 1);
    end

    // R6: serrations after the pulse but before a normal line are blocked
    lines(8);
    base = n_pulse;
    equal(6);
    for (int k = 0; k < 6; k++) seg(27, 5, tf, tr);
    equal(16);
    for (int k = 0; k < 4; k++) seg(27, 5, tf, tr);
    check("R6 blocked before rearm count", n_pulse - base, 1);
    check("R6 blocked before rearm level", int'(vsync_n), 1);
    lines(1);
    seg(27, 5, tf, tr);
    repeat (8) @(negedge clk);
    check("R6 rearmed count", n_pulse - base, 2);
    check("R6 rearmed start", fall_at, tr + LAT);

    // R3 and R2 at the serration threshold
    lines(8);
    base = n_pulse;
    seg(16, 48, tf, tr);
    seg(16, 48, tf, tr);
    check("R3 low of threshold length ignored", n_pulse - base, 0);
    seg(17, 47, tf, tr);
    check("R2 low just over threshold fires", n_pulse - base, 1);
    check("R2 threshold fire start", fall_at, tr + LAT);

    // R7: a one-cycle high inside a broad low does not end the low
    lines(8);
    base = n_pulse;
    csync_n = 1'b0;
    tf = cyc;
    repeat (30) @(negedge clk);
    csync_n = 1'b1;
    @(negedge clk);
    csync_n = 1'b0;
    repeat (69) @(negedge clk);
    csync_n = 1'b1;
    repeat (32) @(negedge clk);
    check("R7 glitch ignored, timeout start", fall_at, tf + LAT + T_OUT);
    equal(12);
    check("R7 single pulse for glitched field", n_pulse - base, 1);

    finish_run();
  end

endmodule